// File: doc/BRIEF.md
# Audio Block Enable Controller

This controller decides when a serial audio block is switched on and off, and what follows from that state. Software raises an enable request to start the block. When software drops the request, the block does not stop at once: an audio frame already under way runs to its end, and the block reaches the off state only at the frame-boundary strobe from the frame generator. A status output reads 1 for the whole time the block is on or winding down. Software polls it until it reads 0, and only then may it request a new start.

The same state drives two other things. The first is the enable for the serial data output pins. Depending on a drive-mode bit, they are driven either only while the block is on, or at all times. The second is the DMA request path, which is split by transfer direction so that a transmit-configured block never raises a receive request.

Top module: `ablk_enable_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `blk_status` is 0, `dout_oe` is all zeros while `drive_always` is 0, and both DMA requests are 0.
- R2: A 0-to-1 change of `en_req`, seen while `blk_status` is 0, makes `blk_status` read 1 after the next clock edge.
- R3: When `en_req` is 0 while the block is running and `frame_busy` is 0, `blk_status` reads 0 after the next clock edge.
- R4: When `en_req` drops while `frame_busy` is 1, `blk_status` stays 1 on every following edge until an edge where `frame_end` is 1, and it reads 0 after that edge.
- R5: When `en_req` drops in the same cycle as `frame_end`, `blk_status` reads 0 after that edge. The ending frame counts as finished.
- R6: A 0-to-1 change of `en_req` while shutdown is pending (`blk_status` is 1 and the request was dropped) is ignored. The block still turns off at the frame end and stays off while `en_req` is held at 1. A fresh 0-to-1 change is needed to restart it.
- R7: With `drive_always` at 0, every bit of `dout_oe` equals `blk_status`.
- R8: With `drive_always` at 1, every bit of `dout_oe` is 1 whatever `blk_status` is.
- R9: `dir_rx` at 0 means transmit. In that case `dma_rx_req` is 0, and `dma_tx_req` is 1 exactly when `dma_en`, `blk_status` and `fifo_thr` are all 1.
- R10: `dir_rx` at 1 means receive. In that case `dma_tx_req` is 0, and `dma_rx_req` is 1 exactly when `dma_en`, `blk_status` and `fifo_thr` are all 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock; all state advances on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| en_req | input | 1 | Software enable request |
| frame_busy | input | 1 | A frame transfer is under way |
| frame_end | input | 1 | One-cycle strobe in the last cycle of a frame |
| drive_always | input | 1 | 0: drive outputs only while on; 1: drive them at all times |
| dir_rx | input | 1 | Transfer direction, 0 transmit, 1 receive |
| dma_en | input | 1 | DMA enable bit |
| fifo_thr | input | 1 | FIFO threshold flag |
| blk_status | output | 1 | Readback state, 1 until fully off |
| dout_oe | output | LANES | Output-enable for each serial data lane |
| dma_tx_req | output | 1 | Qualified transmit DMA request |
| dma_rx_req | output | 1 | Qualified receive DMA request |

## Verification
Two events can land in the same cycle: software dropping the request, and the frame generator's end-of-frame strobe. A third pair is a new enable edge arriving while a stop is still pending. The vector table places the request drop on the very cycle of `frame_end`, and the bench expects the block off one edge later with no stopping phase. It also raises `en_req` again during a long frame and expects the status to fall at the frame end and to stay low while the request is held. A directed test holds the stopping phase over several cycles and checks the status on each edge.

// File: rtl/ablk_pkg.sv
// Package: shared state encoding for the audio block enable controller.
// Assumes: a single kernel clock domain for every user of the type.
package ablk_pkg;
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RUN  = 2'd1,
        ST_STOP = 2'd2
    } blk_state_e;
endpackage

// File: rtl/ablk_enable_fsm.sv
// Module: enable state machine. It moves between off, running and stopping.
// Assumes: frame_end is a one-cycle strobe aligned with the last frame cycle,
// and en_req is already synchronous to clk.
module ablk_enable_fsm
    import ablk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_req,
    input  logic frame_busy,
    input  logic frame_end,
    output logic status
);
    blk_state_e state_q, state_d;
    logic       en_q;
    logic       en_rise;

    // Detect a fresh 0-to-1 change of the enable request.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= en_req;
    end

    assign en_rise = en_req && !en_q;

    // Next-state choice. Off leaves only on a fresh edge, stopping waits for the frame end.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:  if (en_rise) state_d = ST_RUN;
            ST_RUN:  if (!en_req) state_d = (frame_busy && !frame_end) ? ST_STOP : ST_OFF;
            ST_STOP: if (frame_end) state_d = ST_OFF;
            default: state_d = ST_OFF;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    assign status = (state_q != ST_OFF);

    p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF && en_rise) |=> status);
    p_quick_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !en_req && !frame_busy) |=> !status);
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOP && !frame_end) |=> status);
    p_stop_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOP && frame_end) |=> !status);
    p_same_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !en_req && frame_end) |=> !status);
    p_no_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!status && !en_rise) |=> !status);
endmodule

// File: rtl/ablk_out_drive.sv
// Module: output-enable generation for the serial data lanes.
// Assumes: drive_always is static configuration, changed only when the block is off.
module ablk_out_drive #(
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             status,
    input  logic             drive_always,
    output logic [LANES-1:0] oe
);
    // Each lane is driven either always or only while the block is on.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_comb oe[g] = drive_always | status;
    end

    p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!status && !drive_always) |-> (oe == '0));
    p_forced_r8: assert property (@(posedge clk) disable iff (!rst_n)
        drive_always |-> (&oe));
endmodule

// File: rtl/ablk_dma_gate.sv
// Module: qualifies the DMA request by state, threshold and direction.
// Assumes: dir_rx is 0 for transmit, which is the direction after reset.
module ablk_dma_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic status,
    input  logic dma_en,
    input  logic fifo_thr,
    input  logic dir_rx,
    output logic tx_req,
    output logic rx_req
);
    logic qual;

    // Common qualifier, then steer it to one direction only.
    always_comb begin
        qual   = dma_en & status & fifo_thr;
        tx_req = qual & ~dir_rx;
        rx_req = qual &  dir_rx;
    end

    p_one_dir_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_req && rx_req));
    p_tx_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dir_rx |-> !tx_req);
    p_off_no_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !status |-> !(tx_req || rx_req));
endmodule

// File: rtl/ablk_enable_ctrl.sv
// Module: top of the audio block enable controller. It ties the state machine,
// the output drive and the DMA gating together.
// Assumes: every input is synchronous to clk, the kernel clock.
module ablk_enable_ctrl #(
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_req,
    input  logic             frame_busy,
    input  logic             frame_end,
    input  logic             drive_always,
    input  logic             dir_rx,
    input  logic             dma_en,
    input  logic             fifo_thr,
    output logic             blk_status,
    output logic [LANES-1:0] dout_oe,
    output logic             dma_tx_req,
    output logic             dma_rx_req
);
    logic status_w;

    ablk_enable_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_req     (en_req),
        .frame_busy (frame_busy),
        .frame_end  (frame_end),
        .status     (status_w)
    );

    ablk_out_drive #(.LANES(LANES)) u_drive (
        .clk          (clk),
        .rst_n        (rst_n),
        .status       (status_w),
        .drive_always (drive_always),
        .oe           (dout_oe)
    );

    ablk_dma_gate u_dma (
        .clk      (clk),
        .rst_n    (rst_n),
        .status   (status_w),
        .dma_en   (dma_en),
        .fifo_thr (fifo_thr),
        .dir_rx   (dir_rx),
        .tx_req   (dma_tx_req),
        .rx_req   (dma_rx_req)
    );

    assign blk_status = status_w;

    p_rx_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !dir_rx |-> !dma_rx_req);
    p_reset_off_r1: assert property (@(posedge clk)
        !rst_n |=> !blk_status);
endmodule

// File: tb/ablk_enable_ctrl_tb_top.sv
module ablk_enable_ctrl_tb_top;
    localparam int LANES = 2;
    localparam int NVEC  = 17;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_req = 1'b0, frame_busy = 1'b0, frame_end = 1'b0;
    logic drive_always = 1'b0, dir_rx = 1'b0, dma_en = 1'b0, fifo_thr = 1'b0;
    logic             blk_status;
    logic [LANES-1:0] dout_oe;
    logic             dma_tx_req, dma_rx_req;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    ablk_enable_ctrl #(.LANES(LANES)) dut_i (
        .clk(clk), .rst_n(rst_n), .en_req(en_req), .frame_busy(frame_busy),
        .frame_end(frame_end), .drive_always(drive_always), .dir_rx(dir_rx),
        .dma_en(dma_en), .fifo_thr(fifo_thr), .blk_status(blk_status),
        .dout_oe(dout_oe), .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req)
    );

    // Vector bits: [10] en [9] frame_end [8] busy [7] drive_always [6] dir_rx
    // [5] dma_en [4] thr | expected after the edge: [3] status [2] oe [1] tx [0] rx
    localparam logic [10:0] VEC [NVEC] = '{
        11'b0000011_0000, // R1 R9: idle, no request when off
        11'b1000011_1110, // R2 R9: start, transmit request
        11'b1010111_1101, // R10: receive request
        11'b1000110_1100, // R10: threshold low, no request
        11'b0010011_1110, // R4: drop during frame, still on
        11'b1010000_1100, // R6: new edge while stopping, ignored
        11'b1110000_0000, // R4 R6: frame end turns it off
        11'b1000000_0000, // R6: held request does not restart
        11'b0000000_0000, // R6: request released
        11'b1000000_1100, // R2: fresh edge starts
        11'b0000000_0000, // R3: drop with no frame, off next edge
        11'b1000000_1100, // R2: start again
        11'b0110000_0000, // R5: drop on the frame-end cycle
        11'b0001000_0100, // R8: forced drive while off
        11'b0000000_0000, // R7: drive follows status
        11'b1001111_1101, // R8 R10: on, forced drive, receive request
        11'b0000111_0000  // R3 R10: off, receive request gone
    };
    localparam int VREQ [NVEC] = '{1, 2, 10, 10, 4, 6, 4, 6, 6, 2, 3, 2, 5, 8, 7, 10, 3};

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [10:0] v);
        @(negedge clk);
        {en_req, frame_end, frame_busy, drive_always, dir_rx, dma_en, fifo_thr} = v[10:4];
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected <= 20000 cycles", cycles);
            finish_run();
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        check("R1", "status", int'(blk_status), 0);
        check("R1", "oe", int'(dout_oe), 0);
        check("R1", "dma", int'({dma_tx_req, dma_rx_req}), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            string r;
            drive(VEC[i]);
            r = $sformatf("R%0d vec%0d", VREQ[i], i);
            check(r, "status", int'(blk_status), int'(VEC[i][3]));
            check(r, "oe", int'(dout_oe), VEC[i][2] ? (1 << LANES) - 1 : 0);
            check(r, "tx", int'(dma_tx_req), int'(VEC[i][1]));
            check(r, "rx", int'(dma_rx_req), int'(VEC[i][0]));
        end

        // R4: long stopping phase, status checked on every edge
        drive(11'b0000000_0000);
        drive(11'b1000000_0000);
        check("R2", "status", int'(blk_status), 1);
        for (int k = 0; k < 5; k++) begin
            drive(11'b0010000_0000);
            check("R4", "status held", int'(blk_status), 1);
        end
        drive(11'b0110000_0000);
        check("R4", "status at end", int'(blk_status), 0);
        check("R7", "oe at end", int'(dout_oe), 0);

        // R1: reset while stopping clears the state
        drive(11'b1000000_0000);
        drive(11'b0010000_0000);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R1", "status after mid reset", int'(blk_status), 0);
        @(negedge clk);
        rst_n = 1'b1;
        drive(11'b0000000_0000);
        check("R1", "stays off", int'(blk_status), 0);

        finish_run();
    end
endmodule